// File: doc/BRIEF.md
# Low-Power Mode Controller for an 8-bit Microcontroller

This block sits beside a small 8-bit processor core. It runs the core's two low-power states: a light sleep, in which only the CPU clock stops, and a deep sleep, in which the oscillator stops as well. Software enters a state by writing a two-bit mode field. Bit 0 requests light sleep and bit 1 requests deep sleep. The field reads back through `modeBits` and clears itself when the state is left. An enabled pending interrupt ends light sleep. Deep sleep ends only through the hardware reset input.

While the core sleeps, the block takes over the external bus pins. It sets the address-latch and program-fetch strobe levels and tells each of the four I/O ports whether to drive or float, and whether to drive latched data or bus/address content. The pin pattern depends on the sleep state and on the program-memory strap.

When reset ends light sleep, the core keeps running for a short window before the reset sequence takes control. During that window the block blocks RAM writes but leaves port writes alone. When reset ends deep sleep, the block restarts the oscillator at once and holds the CPU clock off for a programmable settling count.

Top module: `lowpwr_ctrl`

## Requirements
- R1: After `rstN` is released, the block is in run mode. In this mode `coreClkEn`=1, `oscEn`=1, `coreRst`=0, `ramWrInhibit`=0 and `modeBits`=00.
- R2: In run mode with `hwRst` low, a `modeWr` pulse with `modeWdata`=01 enters light sleep on the next cycle. In light sleep `coreClkEn`=0 and `oscEn`=1. A write of 00 changes nothing.
- R3: A write with bit 1 set enters deep sleep, even when bit 0 is also set. In deep sleep `coreClkEn`=0 and `oscEn`=0. `modeBits` returns the written value for the whole stay and reads 00 from the cycle after the state is left.
- R4: In light sleep `ale`=1 and `psen`=1, whatever the value of `extMem`.
- R5: In deep sleep, and during the oscillator settling phase that follows it, `ale`=0 and `psen`=0, whatever the value of `extMem`.
- R6: Port controls use one bit per port: bit i of `portDrive` is 1 when port i drives and 0 when it floats, and bit i of `portSrc` is 1 when port i carries bus/address content and 0 when it carries latched data. The values are:
  - Run mode: `portDrive`=1111, and `portSrc`=0101 when `extMem`=1, otherwise 0000.
  - Light sleep with `extMem`=1: `portDrive`=1110 and `portSrc`=0100.
  - Deep sleep with `extMem`=1: `portDrive`=1110 and `portSrc`=0000.
  - Either sleep with `extMem`=0: `portDrive`=1111 and `portSrc`=0000.
- R7: In run mode, the light-sleep reset window and the reset phase, `ale` and `psen` follow `coreAle` and `corePsen`.
- R8: `irqPend` high in light sleep, with `hwRst` low, returns the block to run mode on the next cycle with `coreClkEn`=1 and `modeBits`=00. `irqPend` has no effect in deep sleep.
- R9: Deep sleep is left only through `hwRst`. `oscEn` is 1 in the same cycle in which `hwRst` is 1.
- R10: When `hwRst` ends deep sleep, a settling phase of `STAB_CYCLES` cycles follows with `coreClkEn`=0 and `coreRst`=1, even if `hwRst` falls early. Then the reset phase starts: `coreClkEn`=1 and `coreRst`=1. The reset phase lasts while `hwRst` is high and returns to run mode on the first clock edge at which `hwRst` is low.
- R11: When `hwRst` ends light sleep, a window of `WAKE_MC`×`MACH_CLKS` cycles follows with `coreClkEn`=1, `coreRst`=0 and `ramWrInhibit`=1. This takes priority over a simultaneous `irqPend`. The reset phase of R10 follows the window.
- R12: In run mode, `hwRst` enters the reset phase on the next cycle and clears `modeBits`, and a mode write in that same cycle is ignored. Mode writes outside run mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| hwRst | input | 1 | Hardware reset pin, active high |
| irqPend | input | 1 | An enabled interrupt is pending |
| modeWr | input | 1 | Write strobe for the mode field |
| modeWdata | input | 2 | Mode field write data: bit 0 light sleep, bit 1 deep sleep |
| extMem | input | 1 | Program-memory strap, 1 = external |
| coreAle | input | 1 | Address-latch strobe from the core |
| corePsen | input | 1 | Program-fetch strobe from the core |
| modeBits | output | 2 | Mode field read-back |
| coreClkEn | output | 1 | CPU clock enable |
| oscEn | output | 1 | Oscillator enable |
| coreRst | output | 1 | Reset request to the core |
| ramWrInhibit | output | 1 | Blocks writes to on-chip RAM |
| ale | output | 1 | Address-latch pin level |
| psen | output | 1 | Program-fetch pin level |
| portDrive | output | 4 | Per-port drive (1) / float (0) |
| portSrc | output | 4 | Per-port bus/address (1) / latched data (0) |

## Verification
Two pairs of functions can land in the same cycle. In light sleep, the interrupt wake-up and the reset exit can coincide. In run mode, a mode write and a hardware reset can coincide. The bench raises both inputs of each pair on one clock. It then expects the reset to win: for the first pair, the RAM-inhibit window opens and no return to run mode occurs; for the second, the reset phase starts and the mode field stays clear. A behavioural model of the mode sequence predicts every output on every cycle, so a lost priority shows as a mismatch in the very next cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int NPORT = 4;
  localparam int PORT_ADDR_LO = 0;
  localparam int PORT_ADDR_HI = 2;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_PD   = 2'd2
  } pinMode_e;

  typedef enum logic [2:0] {
    S_RUN  = 3'd0,
    S_IDLE = 3'd1,
    S_PD   = 3'd2,
    S_WAKE = 3'd3,
    S_OSC  = 3'd4,
    S_RST  = 3'd5
  } ctlSt_e;

  typedef struct packed {
    logic     ldMode;
    logic     clrMode;
    pinMode_e pinMode;
  } lpStrb_t;

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int MACH_CLKS   = 12,
  parameter int WAKE_MC     = 2,
  parameter int STAB_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hwRst,
  input  logic       irqPend,
  input  logic       modeWr,
  input  logic [1:0] modeWdata,
  output lpStrb_t    strb,
  output logic       coreClkEn,
  output logic       oscEn,
  output logic       coreRst,
  output logic       ramWrInhibit
);

  localparam int WIN     = WAKE_MC * MACH_CLKS;
  localparam int CNT_MAX = (WIN > STAB_CYCLES) ? WIN : STAB_CYCLES;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(WIN - 1);
  localparam logic [CW-1:0] OSC_LAST = CW'(STAB_CYCLES - 1);

  ctlSt_e        st, stNxt;
  logic [CW-1:0] cnt, cntNxt;
  logic          ldMode, clrMode;

  always_comb begin
    stNxt   = st;
    cntNxt  = cnt;
    ldMode  = 1'b0;
    clrMode = 1'b0;
    case (st)
      S_RUN: begin
        if (hwRst) begin
          stNxt   = S_RST;
          clrMode = 1'b1;
        end else if (modeWr) begin
          ldMode = 1'b1;
          if (modeWdata[1])      stNxt = S_PD;
          else if (modeWdata[0]) stNxt = S_IDLE;
        end
      end
      S_IDLE: begin
        if (hwRst) begin
          stNxt   = S_WAKE;
          cntNxt  = '0;
          clrMode = 1'b1;
        end else if (irqPend) begin
          stNxt   = S_RUN;
          clrMode = 1'b1;
        end
      end
      S_PD: begin
        if (hwRst) begin
          stNxt   = S_OSC;
          cntNxt  = '0;
          clrMode = 1'b1;
        end
      end
      S_WAKE: begin
        if (cnt == WIN_LAST) stNxt = S_RST;
        else                 cntNxt = cnt + 1'b1;
      end
      S_OSC: begin
        if (cnt == OSC_LAST) stNxt = S_RST;
        else                 cntNxt = cnt + 1'b1;
      end
      S_RST: begin
        clrMode = 1'b1;
        if (!hwRst) stNxt = S_RUN;
      end
      default: stNxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= S_RUN;
      cnt <= '0;
    end else begin
      st  <= stNxt;
      cnt <= cntNxt;
    end
  end

  always_comb begin
    strb.ldMode  = ldMode;
    strb.clrMode = clrMode;
    case (st)
      S_IDLE:      strb.pinMode = PM_IDLE;
      S_PD, S_OSC: strb.pinMode = PM_PD;
      default:     strb.pinMode = PM_RUN;
    endcase
  end

  assign coreClkEn    = (st == S_RUN) || (st == S_WAKE) || (st == S_RST);
  assign oscEn        = (st != S_PD) || hwRst;
  assign coreRst      = (st == S_OSC) || (st == S_RST);
  assign ramWrInhibit = (st == S_WAKE);

  // R9: deep sleep holds until the hardware reset pin rises
  a_r9_pd_needs_reset: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_PD && !hwRst) |=> (st == S_PD));

  // R9: the oscillator runs whenever the reset pin is high
  a_r9_osc_on_reset: assert property (@(posedge clk) disable iff (!rstN)
    hwRst |-> oscEn);

  // R11: the RAM-inhibit window only exists while the core clock runs
  a_r11_inhibit_with_clock: assert property (@(posedge clk) disable iff (!rstN)
    ramWrInhibit |-> (coreClkEn && !coreRst));

  // R10: the settling counter never passes its limit
  a_r10_settle_bound: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_OSC) |-> (cnt <= OSC_LAST));

  // R8: an interrupt ends light sleep when no reset is present
  a_r8_irq_wakes: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_IDLE && irqPend && !hwRst) |=> (coreClkEn && !coreRst));

endmodule

// File: rtl/lpm_pindp.sv
module lpm_pindp
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  lpStrb_t          strb,
  input  logic [1:0]       modeWdata,
  input  logic             extMem,
  input  logic             coreAle,
  input  logic             corePsen,
  output logic [1:0]       modeBits,
  output logic             ale,
  output logic             psen,
  output logic [NPORT-1:0] portDrive,
  output logic [NPORT-1:0] portSrc
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              modeBits <= 2'b00;
    else if (strb.clrMode)  modeBits <= 2'b00;
    else if (strb.ldMode)   modeBits <= modeWdata;
  end

  always_comb begin
    case (strb.pinMode)
      PM_IDLE: begin
        ale  = 1'b1;
        psen = 1'b1;
      end
      PM_PD: begin
        ale  = 1'b0;
        psen = 1'b0;
      end
      default: begin
        ale  = coreAle;
        psen = corePsen;
      end
    endcase
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    localparam bit IS_LO = (i == PORT_ADDR_LO);
    localparam bit IS_HI = (i == PORT_ADDR_HI);
    logic drv, src;
    always_comb begin
      case (strb.pinMode)
        PM_IDLE: begin
          drv = !(extMem && IS_LO);
          src = extMem && IS_HI;
        end
        PM_PD: begin
          drv = !(extMem && IS_LO);
          src = 1'b0;
        end
        default: begin
          drv = 1'b1;
          src = extMem && (IS_LO || IS_HI);
        end
      endcase
    end
    assign portDrive[i] = drv;
    assign portSrc[i]   = src;
  end

  // R3: a stored deep-sleep bit always means deep-sleep pins, even with bit 0 set
  a_r3_pd_wins: assert property (@(posedge clk) disable iff (!rstN)
    modeBits[1] |-> (strb.pinMode == PM_PD));

  // R2: a stored light-sleep-only request means light-sleep pins
  a_r2_idle_bits: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits == 2'b01) |-> (strb.pinMode == PM_IDLE));

  // R6: the low address port floats only with external memory in a sleep state
  a_r6_float_only_lp: assert property (@(posedge clk) disable iff (!rstN)
    !portDrive[PORT_ADDR_LO] |-> (extMem && (ale == psen)));

endmodule

// File: rtl/lowpwr_ctrl.sv
module lowpwr_ctrl
  import lpm_pkg::*;
#(
  parameter int MACH_CLKS   = 12,
  parameter int WAKE_MC     = 2,
  parameter int STAB_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hwRst,
  input  logic       irqPend,
  input  logic       modeWr,
  input  logic [1:0] modeWdata,
  input  logic       extMem,
  input  logic       coreAle,
  input  logic       corePsen,
  output logic [1:0] modeBits,
  output logic       coreClkEn,
  output logic       oscEn,
  output logic       coreRst,
  output logic       ramWrInhibit,
  output logic       ale,
  output logic       psen,
  output logic [3:0] portDrive,
  output logic [3:0] portSrc
);

  lpStrb_t strb;

  lpm_ctrl #(
    .MACH_CLKS  (MACH_CLKS),
    .WAKE_MC    (WAKE_MC),
    .STAB_CYCLES(STAB_CYCLES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hwRst       (hwRst),
    .irqPend     (irqPend),
    .modeWr      (modeWr),
    .modeWdata   (modeWdata),
    .strb        (strb),
    .coreClkEn   (coreClkEn),
    .oscEn       (oscEn),
    .coreRst     (coreRst),
    .ramWrInhibit(ramWrInhibit)
  );

  lpm_pindp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .modeWdata(modeWdata),
    .extMem   (extMem),
    .coreAle  (coreAle),
    .corePsen (corePsen),
    .modeBits (modeBits),
    .ale      (ale),
    .psen     (psen),
    .portDrive(portDrive),
    .portSrc  (portSrc)
  );

endmodule

// File: tb/tb_lowpwr_ctrl.sv
`timescale 1ns/1ps
module tb_lowpwr_ctrl;

  localparam int WIN  = 24;
  localparam int STAB = 40;

  logic clk = 1'b0;
  logic rstN, hwRst, irqPend, modeWr, extMem, coreAle, corePsen;
  logic [1:0] modeWdata, modeBits;
  logic coreClkEn, oscEn, coreRst, ramWrInhibit, ale, psen;
  logic [3:0] portDrive, portSrc;

  int nTests = 0;
  int nFail  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  // model: 0 run, 1 light sleep, 2 deep sleep, 3 reset window, 4 settling, 5 reset phase
  int mSt = 0;
  int mCnt = 0;
  logic [1:0] mMode = 2'b00;

  always #4 clk = ~clk;

  lowpwr_ctrl dut (
    .clk(clk), .rstN(rstN), .hwRst(hwRst), .irqPend(irqPend),
    .modeWr(modeWr), .modeWdata(modeWdata), .extMem(extMem),
    .coreAle(coreAle), .corePsen(corePsen), .modeBits(modeBits),
    .coreClkEn(coreClkEn), .oscEn(oscEn), .coreRst(coreRst),
    .ramWrInhibit(ramWrInhibit), .ale(ale), .psen(psen),
    .portDrive(portDrive), .portSrc(portSrc)
  );

  task automatic chk(string tag, string what, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mCnt = 0; mMode = 2'b00;
    end else begin
      case (mSt)
        0: if (hwRst) begin mSt = 5; mMode = 0; end
           else if (modeWr) begin
             mMode = modeWdata;
             if (modeWdata[1]) mSt = 2;
             else if (modeWdata[0]) mSt = 1;
           end
        1: if (hwRst) begin mSt = 3; mCnt = 0; mMode = 0; end
           else if (irqPend) begin mSt = 0; mMode = 0; end
        2: if (hwRst) begin mSt = 4; mCnt = 0; mMode = 0; end
        3: if (mCnt == WIN - 1) mSt = 5; else mCnt++;
        4: if (mCnt == STAB - 1) mSt = 5; else mCnt++;
        default: begin mMode = 0; if (!hwRst) mSt = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      int pm;
      int eClk, eOsc, eRst, eInh, eAle, ePsen, eDrv, eSrc;
      string pTag;
      pm   = (mSt == 1) ? 1 : ((mSt == 2 || mSt == 4) ? 2 : 0);
      eClk = (mSt == 0 || mSt == 3 || mSt == 5) ? 1 : 0;
      eOsc = (mSt != 2 || hwRst) ? 1 : 0;
      eRst = (mSt == 4 || mSt == 5) ? 1 : 0;
      eInh = (mSt == 3) ? 1 : 0;
      if (pm == 1) begin
        eAle = 1; ePsen = 1; pTag = "R4";
        eDrv = extMem ? 4'b1110 : 4'b1111;
        eSrc = extMem ? 4'b0100 : 4'b0000;
      end else if (pm == 2) begin
        eAle = 0; ePsen = 0; pTag = "R5";
        eDrv = extMem ? 4'b1110 : 4'b1111;
        eSrc = 0;
      end else begin
        eAle = coreAle; ePsen = corePsen; pTag = "R7";
        eDrv = 4'b1111;
        eSrc = extMem ? 4'b0101 : 4'b0000;
      end
      chk("R2", "coreClkEn", coreClkEn, eClk);
      chk("R9", "oscEn", oscEn, eOsc);
      chk("R10", "coreRst", coreRst, eRst);
      chk("R11", "ramWrInhibit", ramWrInhibit, eInh);
      chk(pTag, "ale", ale, eAle);
      chk(pTag, "psen", psen, ePsen);
      chk("R6", "portDrive", portDrive, eDrv);
      chk("R6", "portSrc", portSrc, eSrc);
      chk("R3", "modeBits", modeBits, mMode);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      nFail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wrMode(logic [1:0] v);
    modeWr = 1'b1; modeWdata = v;
    step();
    modeWr = 1'b0; modeWdata = 2'b00;
  endtask

  initial begin
    rstN = 0; hwRst = 0; irqPend = 0; modeWr = 0; modeWdata = 0;
    extMem = 0; coreAle = 0; corePsen = 1;
    step(3);
    rstN = 1;
    @(negedge clk);
    chk("R1", "coreClkEn", coreClkEn, 1);
    chk("R1", "oscEn", oscEn, 1);
    chk("R1", "coreRst", coreRst, 0);
    chk("R1", "ramWrInhibit", ramWrInhibit, 0);
    chk("R1", "modeBits", modeBits, 0);
    step();

    // R7: run-mode pass-through under several strobe and strap patterns
    for (int i = 0; i < 8; i++) begin
      coreAle = i[0]; corePsen = i[1]; extMem = i[2];
      step();
    end

    // R2: zero write does nothing, then light sleep with internal memory, R8 wake
    extMem = 0;
    wrMode(2'b00);
    step(2);
    wrMode(2'b01);
    step(5);
    irqPend = 1; step(); irqPend = 0;
    @(negedge clk);
    chk("R8", "coreClkEn after irq", coreClkEn, 1);
    chk("R8", "modeBits after irq", modeBits, 0);
    step(2);

    // R4/R6: light sleep with external memory
    extMem = 1;
    wrMode(2'b01);
    step(4);
    irqPend = 1; step(); irqPend = 0;
    step(2);

    // R3/R5/R9/R10: both bits set, deep sleep wins; irq ignored; long reset
    wrMode(2'b11);
    step(2);
    irqPend = 1; step(4);
    @(negedge clk);
    chk("R8", "coreClkEn with irq in deep sleep", coreClkEn, 0);
    chk("R3", "modeBits in deep sleep", modeBits, 3);
    irqPend = 0;
    step();
    hwRst = 1;
    @(negedge clk);
    chk("R9", "oscEn with reset pin", oscEn, 1);
    step(60);
    hwRst = 0;
    step(3);

    // R10: short reset pulse from deep sleep, internal memory
    extMem = 0;
    wrMode(2'b10);
    step(3);
    hwRst = 1; step(2); hwRst = 0;
    step(STAB + 4);

    // R11: reset and irq in the same cycle in light sleep; writes in window ignored
    wrMode(2'b01);
    step(2);
    hwRst = 1; irqPend = 1; step();
    hwRst = 0;
    step(3);
    modeWr = 1; modeWdata = 2'b10; step(); modeWr = 0; modeWdata = 0;
    irqPend = 0;
    step(WIN + 4);

    // R12: reset and mode write together in run mode
    hwRst = 1; modeWr = 1; modeWdata = 2'b01; step();
    modeWr = 0; modeWdata = 0;
    @(negedge clk);
    chk("R12", "coreRst after reset in run", coreRst, 1);
    chk("R12", "modeBits after reset in run", modeBits, 0);
    chk("R12", "coreClkEn in reset phase", coreClkEn, 1);
    step(3);
    hwRst = 0;
    step(2);

    // R11: light sleep with external memory, reset held past the window
    extMem = 1;
    wrMode(2'b01);
    step(2);
    hwRst = 1;
    step(WIN + 6);
    hwRst = 0;
    step(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule